// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Bank

This block is the software-visible register store of an interrupt routing controller. A host reaches every register through two 32-bit bus windows. One window latches a register index. The other window reads or writes whichever register that index names. Behind the windows sit four kinds of storage:

- a 4-bit controller identity;
- a fixed revision word;
- a 4-bit arbitration identity;
- a routing table with one 64-bit entry per interrupt input. Each entry is split into a lower and an upper 32-bit half at adjacent indices.

The full routing table is driven out in parallel so that the dispatch logic can see every entry at all times. Bus accesses use a single-cycle strobe. Read data returns one cycle after the strobe, together with a valid flag. A wrong access width or an unmapped window offset produces a one-cycle error pulse and changes nothing.

Top module: `irq_route_regbank`

## Requirements
- R1: Bus offset 0 is the select window. A 32-bit write there stores the whole 32-bit value, and a 32-bit read there returns it unchanged.
- R2: An access is illegal if its size code is not 4 bytes, or if its offset is neither 0 nor 16. An illegal access raises `busErr` for exactly one cycle after the strobe, produces no `busRvalid`, and leaves every register unchanged.
- R3: Select index 0 holds the identity. A write through offset 16 keeps only data bits 27:24. A read returns the stored identity in bits 27:24, with every other bit zero.
- R4: Select index 1 is read-only. A read returns NUM_LINES-1 in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits zero. Writes to it change nothing.
- R5: Select index 2 holds the arbitration identity. It uses the same bits 27:24 layout as R3 and is stored independently of the identity.
- R6: Routing entry n has its lower word at select index 0x10+2n and its upper word at 0x10+2n+1, for n from 0 to NUM_LINES-1.
- R7: Writing a lower word keeps only bits 16:0 and clears bits 31:17. Writing an upper word keeps only bits 31:24 and clears bits 23:0.
- R8: After reset the select value is 0, every routing entry is zero, and both the identity and the arbitration identity equal the INIT_ID parameter.
- R9: Select values 3 to 0x0F, and values of 0x10+2*NUM_LINES or above (compared over all 32 bits), read as zero. Writes through them change no register.
- R10: A legal read raises `busRvalid` with its data on `busRdata` in the cycle after the strobe. A write never raises `busRvalid`.
- R11: `routeEntries[64n+63:64n]` always shows entry n as {upper word, lower word}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | BUS_ADDR_W | Byte offset within the block |
| busSize | input | 3 | Access size in bytes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, qualified by busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after a legal read |
| busErr | output | 1 | One-cycle pulse after an illegal access |
| routeEntries | output | 64*NUM_LINES | All routing entries, {upper, lower} per line |

## Verification
The bench builds the block with NUM_LINES = 4, INIT_ID = 0xA and VERSION = 0x20. This shrinks the table to eight words, so a sweep of every select value from 0 to 0x3F reaches all fixed registers, every table half, and the undefined gaps both below and above the table. Two wide select values are added to check that upper select bits are not dropped. Each index is written with a distinct pattern and read back against an arithmetic model. A second read-only pass then confirms that no write leaked into another register. Illegal sizes and offsets are issued afterwards, and the select and data windows are re-read to show that nothing moved.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [31:0] TBL_BASE     = 32'h0000_0010;
  localparam logic [31:0] IDX_ID       = 32'h0000_0000;
  localparam logic [31:0] IDX_VER      = 32'h0000_0001;
  localparam logic [31:0] IDX_ARB      = 32'h0000_0002;
  localparam logic [31:0] LO_KEEP      = 32'h0001_FFFF;
  localparam logic [31:0] HI_KEEP      = 32'hFF00_0000;
  localparam int          OFS_SEL      = 0;
  localparam int          OFS_DATA     = 16;
  localparam logic [2:0]  ACCESS_BYTES = 3'd4;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_SEL,
    SRC_ID,
    SRC_VER,
    SRC_ARB,
    SRC_TBL
  } rdSrcT;

  typedef struct packed {
    logic  wrSel;
    logic  wrId;
    logic  wrArb;
    logic  wrTbl;
    logic  tblHalf;
    logic  rdEn;
    rdSrcT rdSrc;
  } regCtrlT;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES  = 24,
  parameter int BUS_ADDR_W = 8,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic [2:0]            busSize,
  input  logic [31:0]           selReg,
  output regCtrlT               strobes,
  output logic [IDX_W-1:0]      tblIdx,
  output logic                  busErr
);

  localparam logic [31:0] TBL_LIMIT = TBL_BASE + 32'(2 * NUM_LINES);

  logic        atSel;
  logic        atData;
  logic        legal;
  logic        inTable;
  logic [31:0] tblOff;

  always_comb begin
    atSel   = (busAddr == BUS_ADDR_W'(OFS_SEL));
    atData  = (busAddr == BUS_ADDR_W'(OFS_DATA));
    legal   = (busSize == ACCESS_BYTES) && (atSel || atData);
    inTable = (selReg >= TBL_BASE) && (selReg < TBL_LIMIT);
    tblOff  = selReg - TBL_BASE;
    tblIdx  = IDX_W'(tblOff >> 1);
  end

  always_comb begin
    strobes         = '0;
    strobes.rdSrc   = SRC_NONE;
    strobes.tblHalf = tblOff[0];
    if (busValid && legal) begin
      if (atSel) begin
        if (busWrite) begin
          strobes.wrSel = 1'b1;
        end else begin
          strobes.rdEn  = 1'b1;
          strobes.rdSrc = SRC_SEL;
        end
      end else if (busWrite) begin
        if (selReg == IDX_ID)       strobes.wrId  = 1'b1;
        else if (selReg == IDX_ARB) strobes.wrArb = 1'b1;
        else if (inTable)           strobes.wrTbl = 1'b1;
      end else begin
        strobes.rdEn = 1'b1;
        if (selReg == IDX_ID)       strobes.rdSrc = SRC_ID;
        else if (selReg == IDX_VER) strobes.rdSrc = SRC_VER;
        else if (selReg == IDX_ARB) strobes.rdSrc = SRC_ARB;
        else if (inTable)           strobes.rdSrc = SRC_TBL;
        else                        strobes.rdSrc = SRC_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= busValid && !legal;
  end

  AST_VER_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && atData && busSize == ACCESS_BYTES && selReg == IDX_VER)
      |-> !(strobes.wrId || strobes.wrArb || strobes.wrTbl || strobes.wrSel)) // R4
    else $error("version register accepted a write");

  AST_BAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busSize != ACCESS_BYTES) |-> !(strobes.rdEn || strobes.wrSel || strobes.wrTbl)) // R2
    else $error("illegal size produced a strobe");

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int         NUM_LINES = 24,
  parameter logic [3:0] INIT_ID   = 4'h1,
  parameter logic [7:0] VERSION   = 8'h11,
  localparam int        IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regCtrlT                  strobes,
  input  logic [IDX_W-1:0]         tblIdx,
  input  logic [31:0]              busWdata,
  output logic [31:0]              selReg,
  output logic [31:0]              busRdata,
  output logic                     busRvalid,
  output logic [64*NUM_LINES-1:0]  routeEntries
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};

  logic [3:0]  idReg;
  logic [3:0]  arbReg;
  logic [31:0] tblLo [NUM_LINES];
  logic [31:0] tblHi [NUM_LINES];
  logic [31:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= INIT_ID;
      arbReg <= INIT_ID;
    end else begin
      if (strobes.wrSel) selReg <= busWdata;
      if (strobes.wrId)  idReg  <= busWdata[27:24];
      if (strobes.wrArb) arbReg <= busWdata[27:24];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic hit;
    assign hit = strobes.wrTbl && (tblIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblLo[g] <= '0;
        tblHi[g] <= '0;
      end else if (hit) begin
        if (strobes.tblHalf) tblHi[g] <= busWdata & HI_KEEP;
        else                 tblLo[g] <= busWdata & LO_KEEP;
      end
    end

    assign routeEntries[64*g +: 64] = {tblHi[g], tblLo[g]};
  end

  always_comb begin
    case (strobes.rdSrc)
      SRC_SEL: rdNext = selReg;
      SRC_ID:  rdNext = {4'h0, idReg, 24'h0};
      SRC_VER: rdNext = VER_WORD;
      SRC_ARB: rdNext = {4'h0, arbReg, 24'h0};
      SRC_TBL: rdNext = strobes.tblHalf ? tblHi[tblIdx] : tblLo[tblIdx];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRdata  <= strobes.rdEn ? rdNext : '0;
      busRvalid <= strobes.rdEn;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrSel |=> $stable(selReg)) // R1
    else $error("select changed without a select write");

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrId |=> $stable(idReg)) // R3
    else $error("identity changed without a write");

  AST_ARB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrArb |=> $stable(arbReg)) // R5
    else $error("arbitration identity changed without a write");

  AST_LO_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrTbl && !strobes.tblHalf) |=> ((tblLo[$past(tblIdx)] & ~LO_KEEP) == 32'h0)) // R7
    else $error("lower word kept reserved bits");

  AST_HI_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrTbl && strobes.tblHalf) |=> ((tblHi[$past(tblIdx)] & ~HI_KEEP) == 32'h0)) // R7
    else $error("upper word kept reserved bits");

endmodule

// File: rtl/irq_route_regbank.sv
module irq_route_regbank
  import irq_route_pkg::*;
#(
  parameter int         NUM_LINES  = 24,
  parameter int         BUS_ADDR_W = 8,
  parameter logic [3:0] INIT_ID    = 4'h1,
  parameter logic [7:0] VERSION    = 8'h11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busValid,
  input  logic                    busWrite,
  input  logic [BUS_ADDR_W-1:0]   busAddr,
  input  logic [2:0]              busSize,
  input  logic [31:0]             busWdata,
  output logic [31:0]             busRdata,
  output logic                    busRvalid,
  output logic                    busErr,
  output logic [64*NUM_LINES-1:0] routeEntries
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  regCtrlT          strobes;
  logic [IDX_W-1:0] tblIdx;
  logic [31:0]      selReg;

  irq_route_ctrl #(
    .NUM_LINES (NUM_LINES),
    .BUS_ADDR_W(BUS_ADDR_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busSize (busSize),
    .selReg  (selReg),
    .strobes (strobes),
    .tblIdx  (tblIdx),
    .busErr  (busErr)
  );

  irq_route_dp #(
    .NUM_LINES(NUM_LINES),
    .INIT_ID  (INIT_ID),
    .VERSION  (VERSION)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .tblIdx      (tblIdx),
    .busWdata    (busWdata),
    .selReg      (selReg),
    .busRdata    (busRdata),
    .busRvalid   (busRvalid),
    .routeEntries(routeEntries)
  );

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busSize == ACCESS_BYTES && busAddr == BUS_ADDR_W'(OFS_DATA))
      |=> busRvalid) // R10
    else $error("legal read without valid return");

  AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |=> !busRvalid) // R10
    else $error("write produced read valid");

  AST_ERR_EXCLUDES_RVALID: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> !busRvalid) // R2
    else $error("error and read valid together");

endmodule

// File: tb/tb_irq_route_regbank.sv
`timescale 1ns/1ps
module tb_irq_route_regbank;

  localparam int         NL   = 4;
  localparam logic [3:0] INIT = 4'hA;
  localparam logic [7:0] VER  = 8'h20;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busValid = 1'b0;
  logic            busWrite = 1'b0;
  logic [7:0]      busAddr = '0;
  logic [2:0]      busSize = '0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic            busRvalid;
  logic            busErr;
  logic [64*NL-1:0] routeEntries;

  int checks = 0;
  int failures = 0;

  logic [31:0] modelSel;
  logic [3:0]  modelId;
  logic [3:0]  modelArb;
  logic [31:0] modelLo [NL];
  logic [31:0] modelHi [NL];

  always #2.5 clk = ~clk;

  irq_route_regbank #(
    .NUM_LINES (NL),
    .BUS_ADDR_W(8),
    .INIT_ID   (INIT),
    .VERSION   (VER)
  ) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid), .busErr(busErr),
    .routeEntries(routeEntries)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d,
                        output logic [31:0] rd, output logic rv, output logic er);
    @(negedge clk);
    busValid = 1'b1; busWrite = w; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    rd = busRdata; rv = busRvalid; er = busErr;
  endtask

  function automatic string reqOf(input logic [31:0] idx);
    if (idx == 0) return "R3";
    if (idx == 1) return "R4";
    if (idx == 2) return "R5";
    if (idx >= 32'h10 && idx < 32'h10 + 2*NL) return "R6_R7";
    return "R9";
  endfunction

  function automatic logic [31:0] expRead(input logic [31:0] idx);
    if (idx == 0) return {4'h0, modelId, 24'h0};
    if (idx == 1) return {8'h00, 8'(NL - 1), 8'h00, VER};
    if (idx == 2) return {4'h0, modelArb, 24'h0};
    if (idx >= 32'h10 && idx < 32'h10 + 2*NL) begin
      if (idx[0]) return modelHi[(idx - 32'h10) >> 1];
      return modelLo[(idx - 32'h10) >> 1];
    end
    return 32'h0;
  endfunction

  task automatic modelWrite(input logic [31:0] idx, input logic [31:0] d);
    if (idx == 0) modelId = d[27:24];
    else if (idx == 2) modelArb = d[27:24];
    else if (idx >= 32'h10 && idx < 32'h10 + 2*NL) begin
      if (idx[0]) modelHi[(idx - 32'h10) >> 1] = d & 32'hFF00_0000;
      else        modelLo[(idx - 32'h10) >> 1] = d & 32'h0001_FFFF;
    end
  endtask

  task automatic selectAndCheck(input logic [31:0] idx);
    logic [31:0] rd; logic rv; logic er;
    access(1'b1, 8'd0, 3'd4, idx, rd, rv, er);
    check("R10", "select write no rvalid", {63'h0, rv}, 64'h0);
    modelSel = idx;
    access(1'b0, 8'd0, 3'd4, 32'h0, rd, rv, er);
    check("R1", "select readback", {31'h0, rv, rd}, {31'h0, 1'b1, idx});
  endtask

  task automatic readData(input string req, input string what);
    logic [31:0] rd; logic rv; logic er;
    access(1'b0, 8'd16, 3'd4, 32'h0, rd, rv, er);
    check(req, what, {31'h0, rv, rd}, {31'h0, 1'b1, expRead(modelSel)});
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  logic [31:0] sweep [66];

  initial begin
    logic [31:0] rd; logic rv; logic er;
    modelSel = 0; modelId = INIT; modelArb = INIT;
    for (int n = 0; n < NL; n++) begin modelLo[n] = 0; modelHi[n] = 0; end
    for (int i = 0; i < 64; i++) sweep[i] = 32'(i);
    sweep[64] = 32'h0000_0110;
    sweep[65] = 32'hFFFF_FFF0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "reset rvalid/err", {62'h0, busRvalid, busErr}, 64'h0);
    check("R8", "reset table", 64'(routeEntries == '0), 64'h1);
    rstN = 1'b1;

    // R8: reset values seen through the windows
    access(1'b0, 8'd0, 3'd4, 32'h0, rd, rv, er);
    check("R8", "reset select", {31'h0, rv, rd}, {31'h0, 1'b1, 32'h0});
    readData("R8", "reset identity");
    selectAndCheck(32'd2);
    readData("R8", "reset arbitration identity");

    // Sweep: write a distinct pattern at each index, read it back
    for (int i = 0; i < 66; i++) begin
      logic [31:0] pat;
      pat = 32'h9E37_79B9 * (sweep[i] + 32'd1);
      selectAndCheck(sweep[i]);
      access(1'b1, 8'd16, 3'd4, pat, rd, rv, er);
      check("R10", "data write no rvalid", {62'h0, rv, er}, 64'h0);
      modelWrite(sweep[i], pat);
      readData(reqOf(sweep[i]), $sformatf("readback idx %h", sweep[i]));
    end

    // Second pass: nothing leaked between indices (R9)
    for (int i = 0; i < 66; i++) begin
      selectAndCheck(sweep[i]);
      readData(reqOf(sweep[i]), $sformatf("second pass idx %h", sweep[i]));
    end

    // R11: parallel table outputs
    for (int n = 0; n < NL; n++)
      check("R11", $sformatf("entry %0d", n), routeEntries[64*n +: 64], {modelHi[n], modelLo[n]});

    // R2: illegal sizes and offsets
    selectAndCheck(32'h11);
    begin
      logic       bw [5];
      logic [7:0] ba [5];
      logic [2:0] bs [5];
      bw[0] = 1; ba[0] = 8'd16; bs[0] = 3'd2;
      bw[1] = 1; ba[1] = 8'd4;  bs[1] = 3'd4;
      bw[2] = 0; ba[2] = 8'd8;  bs[2] = 3'd4;
      bw[3] = 1; ba[3] = 8'd0;  bs[3] = 3'd1;
      bw[4] = 0; ba[4] = 8'd16; bs[4] = 3'd0;
      for (int k = 0; k < 5; k++) begin
        access(bw[k], ba[k], bs[k], 32'hFFFF_FFFF, rd, rv, er);
        check("R2", $sformatf("illegal access %0d err/rvalid", k), {62'h0, er, rv}, {62'h0, 1'b1, 1'b0});
        @(negedge clk);
        check("R2", $sformatf("illegal access %0d pulse width", k), {63'h0, busErr}, 64'h0);
      end
    end
    access(1'b0, 8'd0, 3'd4, 32'h0, rd, rv, er);
    check("R2", "select unchanged after illegal", {31'h0, rv, rd}, {31'h0, 1'b1, 32'h11});
    readData("R2", "table word unchanged after illegal");
    for (int n = 0; n < NL; n++)
      check("R2", $sformatf("entry %0d unchanged", n), routeEntries[64*n +: 64], {modelHi[n], modelLo[n]});

    // R4: version write with all ones, then read
    selectAndCheck(32'd1);
    access(1'b1, 8'd16, 3'd4, 32'hFFFF_FFFF, rd, rv, er);
    readData("R4", "version after write");
    selectAndCheck(32'd0);
    readData("R3", "identity after version write");

    finish();
  end

endmodule